// File: doc/BRIEF.md
# Event status and mask register

This block is the byte-wide event status and interrupt-enable register of a capacitive-sense counter block. It watches four hardware events:

- rising edges on the raw sense input;
- a carry out of the low counter;
- a carry out of the high counter;
- the end of a pulse-width or period measurement.

Each event is caught in a sticky status bit in the upper nibble. The lower nibble holds one interrupt-enable bit for each event. A single level interrupt goes to the processor.

Software clears a status bit by writing 0 to it. Writing 1 leaves the bit as it is. Because the mask bits share the same byte, a write that changes only the masks must put 1s in the status field.

While the block enable is low, every status bit is held at 0 and new events are dropped. The mask bits stay as they are. The raw sense input is asynchronous. It passes through a two-flop synchronizer, and a rising edge is found by comparing the newest synchronized sample with the sample before it.

Top module: `evt_stat_reg`

## Requirements
- R1: After reset the register reads 0x00 and irq is 0.
- R2: A 0-to-1 change on sense_in sets bit 7. With the input held stable before the clock edge on which it is first sampled, bit 7 reads 1 after the third rising clock edge from that point and still reads 0 after the second. A level held high, or a falling change, does not set bit 7.
- R3: A cycle with carry_lo high while enabled sets bit 6 on that clock edge.
- R4: A cycle with carry_hi high while enabled sets bit 5 on that clock edge.
- R5: A cycle with meas_done high while enabled sets bit 4 on that clock edge.
- R6: A write with bit 7..4 equal to 0 clears the matching status bit. A 1 in those positions leaves the status bit unchanged.
- R7: If an event and a write of 0 to its status bit occur on the same clock edge, the status bit ends up 1.
- R8: While enable is 0, the status bits read 0 from the next clock edge on, and events seen while disabled are never recorded.
- R9: Bits 3..0 are plain read/write mask storage. They are loaded from wr_data[3:0] on every write, are not changed by enable, and are read back in place.
- R10: irq equals the OR over i of (status bit 4+i AND mask bit i). Bit 3 pairs with bit 7, bit 2 with bit 6, bit 1 with bit 5 and bit 0 with bit 4. A mask bit of 0 keeps its event off irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low wipes and freezes status |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: status clear field [7:4], mask [3:0] |
| rd_data | output | 8 | Register read value {status, mask} |
| sense_in | input | 1 | Raw asynchronous sense input |
| carry_lo | input | 1 | Low counter carry-out event |
| carry_hi | input | 1 | High counter carry-out event |
| meas_done | input | 1 | Measurement-complete event |
| irq | output | 1 | Level interrupt to the processor |

## Verification
Each counter event is pulsed on its own while the mask is zero and then after it is enabled. This separates the setting of the status bit from its effect on irq. The sense input is raised, held and dropped, with samples on both sides of the expected latency, to tell edge detection apart from level detection and to pin down the synchronizer depth. Writes are applied with mixed 0s and 1s in the status field, and once on the same edge as an event, to tell write-0-to-clear from plain storage and to confirm that a set wins. Events and mask writes arrive while the block is disabled, followed by re-enabling with the sense input already high, to show that the wipe covers status only and that no event is carried over.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_EVT = 4;
  localparam int REG_W   = 2 * NUM_EVT;

  typedef logic [NUM_EVT-1:0] evt_vec_t;

  // Next value of one sticky status bit: disable wipes, a write of 0 clears,
  // and an event in the same cycle wins over the clear.
  function automatic logic sticky_next(input logic cur, input logic evt,
                                       input logic en, input logic wr,
                                       input logic wbit);
    logic kept;
    kept = (wr && !wbit) ? 1'b0 : cur;
    return en ? (kept | evt) : 1'b0;
  endfunction

  function automatic logic irq_of(input evt_vec_t st, input evt_vec_t mk);
    return |(st & mk);
  endfunction
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic               cur_smp;
  logic               prev_smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], async_in};
  end

  assign cur_smp  = chain_q[SYNC_STAGES-1];
  assign prev_smp = chain_q[SYNC_STAGES];
  assign rise     = cur_smp & ~prev_smp;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R2
endmodule

// File: rtl/evt_sticky.sv
module evt_sticky
  import evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  evt_vec_t evt,
  input  logic     wr,
  input  evt_vec_t wr_st,
  output evt_vec_t st
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= 1'b0;
      else        st[i] <= sticky_next(st[i], evt[i], en, wr, wr_st[i]);
    end
  end

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> st == '0); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && evt != '0) |=> ((st & $past(evt)) == $past(evt))); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & ~$past(st) & ~$past(evt)) == '0)); // R2
  AST_CLEAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr && evt == '0) |=> st == $past(st & wr_st)); // R6
endmodule

// File: rtl/evt_irq.sv
module evt_irq
  import evt_pkg::*;
(
  input  evt_vec_t st,
  input  evt_vec_t mk,
  output logic     irq
);
  assign irq = irq_of(st, mk);
endmodule

// File: rtl/evt_stat_reg.sv
module evt_stat_reg
  import evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             sense_in,
  input  logic             carry_lo,
  input  logic             carry_hi,
  input  logic             meas_done,
  output logic             irq
);
  logic     sense_rise;
  evt_vec_t evt_vec;
  evt_vec_t status_q;
  evt_vec_t mask_q;

  evt_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sense_in), .rise(sense_rise)
  );

  // Order matters: index 3 is the sense edge, down to index 0 measurement done.
  assign evt_vec = {sense_rise, carry_lo, carry_hi, meas_done};

  evt_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .en(enable), .evt(evt_vec),
    .wr(wr_en), .wr_st(wr_data[REG_W-1:NUM_EVT]), .st(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_data[NUM_EVT-1:0];
  end

  evt_irq u_irq (.st(status_q), .mk(mask_q), .irq(irq));

  assign rd_data = {status_q, mask_q};

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q)); // R9
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[NUM_EVT-1:0] == $past(wr_data[NUM_EVT-1:0])); // R9
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(rd_data[REG_W-1:NUM_EVT] & rd_data[NUM_EVT-1:0]))); // R10
endmodule

// File: tb/evt_stat_reg_test.sv
module evt_stat_reg_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       enable = 1;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       sense_in = 0;
  logic       carry_lo = 0;
  logic       carry_hi = 0;
  logic       meas_done = 0;
  logic       irq;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  evt_stat_reg uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sense_in(sense_in),
    .carry_lo(carry_lo), .carry_hi(carry_hi), .meas_done(meas_done), .irq(irq)
  );

  always #5 clk = ~clk;

  // Behavioural reference: history of sense samples, newest first.
  bit   hist[$];
  bit [3:0] m_st, m_mk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_st = 0;
      m_mk = 0;
    end else begin
      bit edge_seen;
      bit [3:0] ev;
      edge_seen = hist[1] && !hist[2];
      ev = {edge_seen, carry_lo, carry_hi, meas_done};
      if (!enable) m_st = 0;
      else begin
        if (wr_en) m_st = m_st & wr_data[7:4];
        m_st = m_st | ev;
      end
      if (wr_en) m_mk = wr_data[3:0];
      hist.push_front(sense_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (rd_data !== {m_st, m_mk} || irq !== (|(m_st & m_mk))) begin
        n_fail++;
        $display("FAIL %s model: rd=%h irq=%b expected rd=%h irq=%b",
                 cur_req, rd_data, irq, {m_st, m_mk}, |(m_st & m_mk));
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] exp_rd, input logic exp_irq);
    n_tests++;
    if (rd_data !== exp_rd || irq !== exp_irq) begin
      n_fail++;
      $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b",
               req, rd_data, irq, exp_rd, exp_irq);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: carry_lo = 1;
      1: carry_hi = 1;
      default: meas_done = 1;
    endcase
    @(negedge clk);
    carry_lo = 0; carry_hi = 0; meas_done = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 8'h00, 0);

    cur_req = "R3";
    wr(8'hF0);
    pulse(0);
    chk("R3", 8'h40, 0);
    cur_req = "R10";
    wr(8'hF4);
    chk("R10", 8'h44, 1);
    cur_req = "R4";
    pulse(1);
    chk("R4", 8'h64, 1);
    cur_req = "R5";
    pulse(2);
    chk("R5", 8'h74, 1);

    cur_req = "R6";
    wr(8'hB4);
    chk("R6", 8'h34, 0);

    cur_req = "R2";
    @(negedge clk); sense_in = 1;
    wait_n(2);
    chk("R2", 8'h34, 0);
    @(negedge clk);
    chk("R2", 8'hB4, 0);
    wait_n(3);
    wr(8'h74);
    wait_n(4);
    chk("R2", 8'h34, 0);
    @(negedge clk); sense_in = 0;
    wait_n(5);
    chk("R2", 8'h34, 0);

    cur_req = "R7";
    @(negedge clk); wr_en = 1; wr_data = 8'h04; carry_hi = 1;
    @(negedge clk); wr_en = 0; carry_hi = 0;
    chk("R7", 8'h24, 0);

    cur_req = "R8";
    @(negedge clk); enable = 0;
    @(negedge clk);
    chk("R8", 8'h04, 0);
    pulse(0);
    pulse(2);
    @(negedge clk); sense_in = 1;
    cur_req = "R9";
    wr(8'h0A);
    wait_n(4);
    chk("R9", 8'h0A, 0);
    cur_req = "R8";
    @(negedge clk); enable = 1;
    wait_n(3);
    chk("R8", 8'h0A, 0);

    cur_req = "R10";
    @(negedge clk); sense_in = 0;
    wait_n(3);
    @(negedge clk); sense_in = 1;
    wait_n(3);
    chk("R10", 8'h8A, 1);
    wr(8'hFF);
    chk("R9", 8'h8F, 1);
    pulse(0);
    chk("R3", 8'hCF, 1);
    wr(8'h7F);
    chk("R6", 8'h4F, 1);
    wr(8'hF0);
    chk("R10", 8'h40, 0);

    wait_n(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule